// File: doc/BRIEF.md
# Packed-Word Configuration Register Target

This block is an I2C target that owns a small bank of 9-bit configuration registers. A host reaches it through two lines, SCL and SDA. The block samples both with its own system clock and finds bus conditions from the sampled levels. It pulls SDA low through an open-drain enable and never drives it high. Each access carries one 16-bit word. The upper seven bits of the word select a register, and the lower nine bits are that register's value. Because the word is packed this way, the ninth data bit travels as the least significant bit of the first byte after the device address.

To write, the host sends the device address with a write flag, then the two halves of the word, and then closes with STOP. To read, the host first sends the register index in a write phase. It then issues a repeated START and the device address with a read flag, and clocks out two bytes from the target. The target answers only its own 7-bit address. It stays off the bus for any other address until the next START.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset, register i holds (17*i + 3) mod 512, and sda_oe is 0.
- R2: The device address is 7'b0011010 followed by the R/W flag (0 = write, 1 = read), and the target acknowledges it. Any other address gets no acknowledge, and the target keeps SDA released for every following byte until the next START.
- R3: In a write, the first byte after the address is {index[6:0], data[8]} and the second byte is data[7:0], both MSB first. The target acknowledges each byte.
- R4: A register is updated only after the second word byte has been acknowledged. A STOP before that point leaves every register unchanged.
- R5: In a read, the write phase carries {index[6:0], 0}. After a repeated START and the address with R/W=1, the target sends {7'b0, data[8]} and then data[7:0], both MSB first.
- R6: If the host does not acknowledge a read byte, the target releases SDA and drives nothing more until START or STOP.
- R7: After the second read byte, the target releases SDA even if the host acknowledges, so any further byte reads as 8'hFF.
- R8: An index at or above NUM_REGS (default 16) reads as zero, and a write to it changes no register.
- R9: sda_oe changes only after a sampled SCL falling edge, a START or a STOP. A STOP always releases SDA.
- R10: After a complete word has been written, any further byte in the same transfer is not acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the data line is pulled low |

## Verification
The assertions are checked on every cycle. They confirm that:
- the data-line enable moves only after an SCL fall, a START or a STOP;
- a STOP releases the line;
- a START returns the target to address reception;
- a refused address never leads to the line being pulled;
- a register changes only in a cycle that carries a write strobe.

Only the bench's transfers can show the rest: the packing of the ninth bit in both directions, the discarding of a word cut short by STOP, aliasing of out-of-range indices, and the released line after a host NACK or after the second read byte.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
    localparam int IDX_W  = 7;
    localparam int DATA_W = 9;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_HI, ST_LO, ST_ACK, ST_TX, ST_MACK, ST_WAIT
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic [DATA_W-1:0] reg_default(int i);
        return DATA_W'((i * 17 + 3) % 512);
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import cfg_i2c_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_in};
            sda_ff <= {sda_ff[0], sda_in};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    always_comb begin
        ev.rise  = scl_ff[1] & ~scl_q;
        ev.fall  = ~scl_ff[1] & scl_q;
        ev.start = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
        ev.stop  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
        ev.sda   = sda_ff[1];
    end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int SW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= reg_default(g);
            else if (we && waddr == IDX_W'(g))
                mem[g] <= wdata;
        end

        // R4 / R8: an entry moves only on a strobe aimed at that entry
        p_entry_only_on_write_r4: assert property (@(posedge clk) disable iff (rst)
            !$stable(mem[g]) |-> ($past(we) && $past(waddr) == IDX_W'(g)));
    end

    always_comb begin
        if ({1'b0, raddr} < (IDX_W+1)'(NUM_REGS))
            rdata = mem[raddr[SW-1:0]];
        else
            rdata = '0;
    end
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter logic [IDX_W-1:0] DEV_ADDR = 7'b0011010,
    parameter int               NUM_REGS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    bus_ev_t            ev;
    tgt_state_e         st, ack_nxt;
    logic [2:0]         cnt;
    logic               got8, second, mack_ok, wr_pend;
    logic [BYTE_W-1:0]  sh, tx;
    logic [IDX_W-1:0]   idx;
    logic               d8;
    logic [DATA_W-1:0]  rdata;
    logic               wr_en;
    logic [BYTE_W-1:0]  hi_byte;

    i2c_line_sync u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    cfg_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst), .we(wr_en), .waddr(idx),
        .wdata({d8, sh}), .raddr(idx), .rdata(rdata)
    );

    assign wr_en   = (st == ST_ACK) && ev.fall && wr_pend;
    assign hi_byte = {{(BYTE_W-1){1'b0}}, rdata[DATA_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ack_nxt <= ST_IDLE;
            sda_oe  <= 1'b0;
            cnt     <= '0;
            got8    <= 1'b0;
            second  <= 1'b0;
            mack_ok <= 1'b0;
            wr_pend <= 1'b0;
            sh      <= '0;
            tx      <= '0;
            idx     <= '0;
            d8      <= 1'b0;
        end else if (ev.stop) begin
            st      <= ST_IDLE;
            sda_oe  <= 1'b0;
            wr_pend <= 1'b0;
        end else if (ev.start) begin
            st      <= ST_ADDR;
            sda_oe  <= 1'b0;
            cnt     <= '0;
            got8    <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            unique case (st)
                ST_ADDR, ST_HI, ST_LO: begin
                    if (ev.rise) begin
                        sh  <= {sh[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) got8 <= 1'b1;
                    end else if (ev.fall && got8) begin
                        got8 <= 1'b0;
                        if (st == ST_ADDR) begin
                            if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                                sda_oe  <= 1'b1;
                                st      <= ST_ACK;
                                ack_nxt <= sh[0] ? ST_TX : ST_HI;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end else if (st == ST_HI) begin
                            idx     <= sh[BYTE_W-1:1];
                            d8      <= sh[0];
                            sda_oe  <= 1'b1;
                            st      <= ST_ACK;
                            ack_nxt <= ST_LO;
                        end else begin
                            sda_oe  <= 1'b1;
                            st      <= ST_ACK;
                            ack_nxt <= ST_WAIT;
                            wr_pend <= 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        wr_pend <= 1'b0;
                        cnt     <= '0;
                        st      <= ack_nxt;
                        if (ack_nxt == ST_TX) begin
                            tx     <= hi_byte;
                            sda_oe <= ~hi_byte[BYTE_W-1];
                            second <= 1'b0;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            st     <= ST_MACK;
                        end else begin
                            tx     <= tx << 1;
                            sda_oe <= ~tx[BYTE_W-2];
                            cnt    <= cnt + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        mack_ok <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (mack_ok && !second) begin
                            tx     <= rdata[BYTE_W-1:0];
                            sda_oe <= ~rdata[BYTE_W-1];
                            st     <= ST_TX;
                            cnt    <= '0;
                            second <= 1'b1;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: the line moves only after an SCL fall, START or STOP
    p_oe_moves_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(ev.fall || ev.start || ev.stop));

    // R9: a STOP always leaves the line released
    p_stop_releases_r9: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    // R2: START resynchronises to address reception
    p_start_to_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !ev.stop) |=> (st == ST_ADDR && !sda_oe));

    // R2: an address that was refused never pulls the line
    p_refused_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && $past(st) == ST_ADDR) |-> !sda_oe);
endmodule

// File: tb/sim_cfg_i2c_target.sv
module sim_cfg_i2c_target;
    localparam int Q = 16;
    localparam logic [6:0] DEV = 7'b0011010;
    localparam int NREG = 16;

    localparam logic [15:0] VEC [6] = '{
        {7'd0,  9'h1FF}, {7'd1,  9'h100}, {7'd7,  9'h0AA},
        {7'd15, 9'h055}, {7'd9,  9'h000}, {7'd2,  9'h13C}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    cfg_i2c_target u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(Q/2);
        scl = 1'b1;   waitc(Q);
        sda_m = 1'b0; waitc(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        waitc(Q/2); sda_m = 1'b0;
        waitc(Q/2); scl = 1'b1;
        waitc(Q);   sda_m = 1'b1;
        waitc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            waitc(Q/2); sda_m = b[i];
            waitc(Q/2); scl = 1'b1;
            waitc(Q);   scl = 1'b0;
        end
        waitc(Q/2); sda_m = 1'b1;
        waitc(Q/2); scl = 1'b1;
        waitc(Q/2); ack = ~sda_line;
        waitc(Q/2); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitc(Q);   scl = 1'b1;
            waitc(Q/2); b[i] = sda_line;
            waitc(Q/2); scl = 1'b0;
        end
        waitc(Q/2); sda_m = nack;
        waitc(Q/2); scl = 1'b1;
        waitc(Q);   scl = 1'b0;
        waitc(Q/2); sda_m = 1'b1;
    endtask

    task automatic write_word(input logic [6:0] ix, input logic [8:0] d,
                              output logic [2:0] acks);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); acks[2] = a;
        send_byte({ix, d[8]}, a);  acks[1] = a;
        send_byte(d[7:0], a);      acks[0] = a;
        bus_stop();
    endtask

    task automatic read_word(input logic [6:0] ix, output logic [7:0] hi,
                             output logic [7:0] lo, output logic [2:0] acks);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); acks[2] = a;
        send_byte({ix, 1'b0}, a);  acks[1] = a;
        bus_start();
        send_byte({DEV, 1'b1}, a); acks[0] = a;
        recv_byte(1'b0, hi);
        recv_byte(1'b1, lo);
        bus_stop();
    endtask

    function automatic logic [8:0] dflt(input int i);
        return 9'((17 * i + 3) % 512);
    endfunction

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [2:0] ak;
        logic [7:0] hi, lo, xb;
        logic a;
        waitc(5);
        rst = 1'b0;
        waitc(4);
        chk("R1 sda_oe after reset", int'(sda_oe), 0);

        // R1: defaults
        read_word(7'd5, hi, lo, ak);
        chk("R1 default hi r5", int'(hi), int'({7'b0, dflt(5)[8]}));
        chk("R1 default lo r5", int'(lo), int'(dflt(5) & 9'hFF));
        read_word(7'd15, hi, lo, ak);
        chk("R1 default hi r15", int'(hi), int'({7'b0, dflt(15)[8]}));
        chk("R1 default lo r15", int'(lo), int'(dflt(15) & 9'hFF));
        chk("R9 released after stop", int'(sda_oe), 0);

        // R3 / R5: vector walk
        foreach (VEC[k]) begin
            write_word(VEC[k][15:9], VEC[k][8:0], ak);
            chk("R3 write acks", int'(ak), 7);
            read_word(VEC[k][15:9], hi, lo, ak);
            chk("R5 read acks", int'(ak), 7);
            chk("R5 upper byte", int'(hi), int'({7'b0, VEC[k][8]}));
            chk("R5 lower byte", int'(lo), int'(VEC[k][7:0]));
        end

        // R2: wrong address
        bus_start();
        send_byte({7'b0011011, 1'b0}, a);
        chk("R2 no ack for foreign address", int'(a), 0);
        send_byte(8'h00, a);
        chk("R2 silent until START", int'(a), 0);
        bus_stop();
        chk("R2 line released", int'(sda_oe), 0);

        // R4: STOP after first word byte discards
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte({7'd3, 1'b1}, a);
        bus_stop();
        read_word(7'd3, hi, lo, ak);
        chk("R4 partial word discarded hi", int'(hi), int'({7'b0, dflt(3)[8]}));
        chk("R4 partial word discarded lo", int'(lo), int'(dflt(3) & 9'hFF));

        // R8: out-of-range index
        write_word(7'd100, 9'h155, ak);
        read_word(7'd100, hi, lo, ak);
        chk("R8 out-of-range reads zero", int'({hi, lo}), 0);
        read_word(7'd4, hi, lo, ak);
        chk("R8 no alias write to r4", int'({hi[0], lo}), int'(dflt(4)));

        // R6: host NACK on first read byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte({7'd5, 1'b0}, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b1, hi);
        recv_byte(1'b1, xb);
        bus_stop();
        chk("R6 released after host NACK", int'(xb), 8'hFF);

        // R7: host ACKs second byte, third byte reads released line
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte({7'd1, 1'b0}, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b0, hi);
        recv_byte(1'b0, lo);
        recv_byte(1'b1, xb);
        bus_stop();
        chk("R7 lower byte r1", int'(lo), 8'h00);
        chk("R7 extra read byte released", int'(xb), 8'hFF);

        // R10: extra byte after complete word
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte({7'd6, 1'b0}, a);
        send_byte(8'h3C, a);
        send_byte(8'hC3, a);
        chk("R10 extra byte not acked", int'(a), 0);
        bus_stop();
        read_word(7'd6, hi, lo, ak);
        chk("R10 word kept", int'({hi[0], lo}), 9'h03C);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule